// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Write Slave

This block is the slave side of a three-wire serial EEPROM, reduced to the write path. A host selects the device with a chip-select line and shifts a command in on a serial data line, one bit for each serial clock pulse. The block decodes the command and stores the payload in its internal array. It then runs a self-timed programming interval, counted in system clocks. During that interval and after it, the host can poll ready/busy on the serial data-out pin.

A strap input chooses the word width. With the strap low the array is addressed as bytes. With it high the array is addressed as 16-bit words. Both modes share one storage of 2^WORD_ADDR_W words built from two byte lanes. A synthesis parameter selects when programming starts: on the falling edge of chip select, or on the serial-clock edge that samples the last data bit. All pins are sampled by the system clock `clk`, and serial-clock edges are detected in that domain. A registered read port lets neighbouring logic see the array.

Top module: `mw_eeprom_wr`

## Requirements
- R1: A write frame is a 1 start bit, the opcode bits 0 then 1, the address (MSB first) and then the data (MSB first). Each bit is taken from `di` on a rising edge of `sck` while `cs` is high. Zeros before the start bit are ignored.
- R2: With `org` low, the address is 9 bits and the data is 8 bits. Address bits [8:1] pick the word, and address bit 0 picks the byte lane: 0 is bits [7:0] and 1 is bits [15:8]. The other lane is left unchanged. With `org` high, the address is 8 bits and the data is 16 bits, written to the whole word.
- R3: With TRIG_ON_CS=1, the write is committed on the fall of `cs` after a complete frame. With TRIG_ON_CS=0, it is committed on the `sck` rise that samples the last data bit, while `cs` is still high.
- R4: After a write is committed, programming lasts PROG_CYCLES clocks. `cs` may then be raised after being low for at least CSL_MIN clocks. In that case `do_oe` is 1 while `cs` stays high, and `do_o` is 0 while programming runs and 1 once it has finished.
- R5: Raising `cs` after a low time shorter than CSL_MIN clocks leaves `do_oe` at 0.
- R6: `do_oe` is 0 after reset, while `cs` is low, and whenever no write has been committed since reset or since the last clear.
- R7: A start bit clocked in while status is shown, followed by `cs` going low, removes the status. Later raises of `cs` leave `do_oe` at 0 until the next committed write.
- R8: A frame whose start bit arrives while programming runs is ignored, and the array is unchanged.
- R9: If `cs` falls before the last data bit, the frame is discarded and the array is unchanged.
- R10: A frame with any opcode other than binary 01 is absorbed without changing the array.
- R11: `rd_data` shows the word at `rd_addr` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in |
| org | input | 1 | Width strap: 0 selects byte mode, 1 selects word mode |
| do_o | output | 1 | Serial data out; carries ready (1) or busy (0) |
| do_oe | output | 1 | Output enable for `do_o`; 0 means the pin is high-impedance |
| rd_addr | input | WORD_ADDR_W | Word address for the read port |
| rd_data | output | 16 | Registered array word at `rd_addr` |

## Verification
The checker watches the status pin on every cycle. It confirms that the pin is only enabled while chip select is high, and only after a long enough low time. It confirms that the pin reads busy or ready according to the clocks elapsed since the last committed write. It also confirms that no write commits during programming, and that each commit happens on the edge its variant names. Array contents cannot be seen from properties like these. Byte-lane merging, bit order, the discarding of partial, foreign-opcode and busy-time frames, and the clear of status by a start bit are shown only by the bench's scenarios. The bench drives both trigger variants side by side and reads the results back through the read port.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_OP,
    RX_PAY,
    RX_DONE,
    RX_SKIP
  } rx_state_t;

  localparam logic [1:0] OP_WRITE = 2'b01;
endpackage

// File: rtl/mw_edge.sv
module mw_edge #(
  parameter int CSL_MIN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sck,
  output logic sck_rise,
  output logic cs_rise,
  output logic cs_fall,
  output logic csl_ok
);
  localparam int CW = $clog2(CSL_MIN + 1);
  localparam logic [CW-1:0] LOW_MAX = CW'(CSL_MIN);

  logic          cs_q;
  logic          sck_q;
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q    <= 1'b0;
      sck_q   <= 1'b0;
      low_cnt <= '0;
    end else begin
      cs_q  <= cs;
      sck_q <= sck;
      if (cs)
        low_cnt <= '0;
      else if (low_cnt != LOW_MAX)
        low_cnt <= low_cnt + 1'b1;
    end
  end

  assign sck_rise = sck & ~sck_q;
  assign cs_rise  = cs & ~cs_q;
  assign cs_fall  = ~cs & cs_q;
  assign csl_ok   = (low_cnt >= LOW_MAX);
endmodule

// File: rtl/mw_frame_rx.sv
module mw_frame_rx
  import mw_pkg::*;
#(
  parameter int WORD_ADDR_W = 8,
  parameter bit TRIG_ON_CS  = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cs,
  input  logic                   di,
  input  logic                   org,
  input  logic                   sck_rise,
  input  logic                   cs_fall,
  input  logic                   busy,
  output logic                   start_bit,
  output logic                   wr_go,
  output logic [WORD_ADDR_W-1:0] wr_addr,
  output logic [15:0]            wr_data,
  output logic [1:0]             wr_be
);
  localparam int BADDR_W  = WORD_ADDR_W + 1;
  localparam int SH_W     = WORD_ADDR_W + 16;
  localparam int LEN_BYTE = BADDR_W + 8;
  localparam int CNT_W    = $clog2(SH_W + 1);

  rx_state_t        st;
  logic [CNT_W-1:0] cnt;
  logic             op_hi;
  logic             org_l;
  logic [SH_W-1:0]  sh;
  logic [SH_W-1:0]  sh_n;
  logic [SH_W-1:0]  src;
  logic             clk_edge;
  logic             last;
  logic             fire_clk;
  logic             fire_cs;

  always_comb begin
    clk_edge  = cs & sck_rise;
    sh_n      = {sh[SH_W-2:0], di};
    last      = (cnt == (org_l ? CNT_W'(SH_W - 1) : CNT_W'(LEN_BYTE - 1)));
    start_bit = clk_edge && (st == RX_IDLE) && di;
    fire_clk  = !TRIG_ON_CS && clk_edge && (st == RX_PAY) && last;
    fire_cs   = TRIG_ON_CS && (st == RX_DONE) && cs_fall;
    wr_go     = fire_clk | fire_cs;
    src       = fire_clk ? sh_n : sh;
    if (org_l) begin
      wr_addr = src[SH_W-1:16];
      wr_data = src[15:0];
      wr_be   = 2'b11;
    end else begin
      wr_addr = src[LEN_BYTE-1:9];
      wr_data = {2{src[7:0]}};
      wr_be   = src[8] ? 2'b10 : 2'b01;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= RX_IDLE;
      cnt   <= '0;
      op_hi <= 1'b0;
      org_l <= 1'b0;
      sh    <= '0;
    end else if (!cs) begin
      st <= RX_IDLE;
    end else if (sck_rise) begin
      case (st)
        RX_IDLE: begin
          if (di) begin
            st    <= busy ? RX_SKIP : RX_OP;
            cnt   <= '0;
            org_l <= org;
            sh    <= '0;
          end
        end
        RX_OP: begin
          op_hi <= di;
          cnt   <= cnt + 1'b1;
          if (cnt != '0) begin
            cnt <= '0;
            st  <= ({op_hi, di} == OP_WRITE) ? RX_PAY : RX_SKIP;
          end
        end
        RX_PAY: begin
          sh  <= sh_n;
          cnt <= cnt + 1'b1;
          if (last)
            st <= TRIG_ON_CS ? RX_DONE : RX_SKIP;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int PROG_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic wr_go,
  input  logic start_bit,
  input  logic cs_rise,
  input  logic cs_fall,
  input  logic csl_ok,
  output logic busy,
  output logic do_o,
  output logic do_oe
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_n;
  logic          armed;
  logic          clr_pend;
  logic          win;
  logic          win_n;

  always_comb begin
    if (wr_go)
      cnt_n = CW'(PROG_CYCLES);
    else if (cnt != '0)
      cnt_n = cnt - 1'b1;
    else
      cnt_n = cnt;
    if (cs_rise)
      win_n = armed & csl_ok;
    else
      win_n = cs & win;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      armed    <= 1'b0;
      clr_pend <= 1'b0;
      win      <= 1'b0;
      do_o     <= 1'b0;
    end else begin
      cnt  <= cnt_n;
      win  <= win_n;
      do_o <= win_n & (cnt_n == '0);
      if (wr_go)
        armed <= 1'b1;
      else if (cs_fall && clr_pend)
        armed <= 1'b0;
      if (cs_fall)
        clr_pend <= 1'b0;
      else if (start_bit && win)
        clr_pend <= 1'b1;
    end
  end

  assign busy  = (cnt != '0);
  assign do_oe = win;
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int WORD_ADDR_W = 8
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [1:0]             be,
  input  logic [WORD_ADDR_W-1:0] waddr,
  input  logic [15:0]            wdata,
  input  logic [WORD_ADDR_W-1:0] raddr,
  output logic [15:0]            rdata
);
  localparam int DEPTH = 1 << WORD_ADDR_W;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (we && be[g])
        mem[waddr] <= wdata[g*8 +: 8];
      q <= mem[raddr];
    end
  end

  assign rdata = {g_lane[1].q, g_lane[0].q};
endmodule

// File: rtl/mw_eeprom_wr.sv
module mw_eeprom_wr #(
  parameter int WORD_ADDR_W = 8,
  parameter int PROG_CYCLES = 2000,
  parameter int CSL_MIN     = 8,
  parameter bit TRIG_ON_CS  = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cs,
  input  logic                   sck,
  input  logic                   di,
  input  logic                   org,
  output logic                   do_o,
  output logic                   do_oe,
  input  logic [WORD_ADDR_W-1:0] rd_addr,
  output logic [15:0]            rd_data
);
  logic                   sck_rise;
  logic                   cs_rise;
  logic                   cs_fall;
  logic                   csl_ok;
  logic                   busy;
  logic                   start_bit;
  logic                   wr_go;
  logic [WORD_ADDR_W-1:0] wr_addr;
  logic [15:0]            wr_data;
  logic [1:0]             wr_be;

  mw_edge #(.CSL_MIN(CSL_MIN)) u_edge (
    .clk(clk), .rst(rst), .cs(cs), .sck(sck),
    .sck_rise(sck_rise), .cs_rise(cs_rise), .cs_fall(cs_fall), .csl_ok(csl_ok)
  );

  mw_frame_rx #(.WORD_ADDR_W(WORD_ADDR_W), .TRIG_ON_CS(TRIG_ON_CS)) u_rx (
    .clk(clk), .rst(rst), .cs(cs), .di(di), .org(org),
    .sck_rise(sck_rise), .cs_fall(cs_fall), .busy(busy),
    .start_bit(start_bit), .wr_go(wr_go),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be)
  );

  mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .cs(cs), .wr_go(wr_go), .start_bit(start_bit),
    .cs_rise(cs_rise), .cs_fall(cs_fall), .csl_ok(csl_ok),
    .busy(busy), .do_o(do_o), .do_oe(do_oe)
  );

  mw_array #(.WORD_ADDR_W(WORD_ADDR_W)) u_array (
    .clk(clk), .we(wr_go), .be(wr_be), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/mw_eeprom_wr_chk.sv
module mw_eeprom_wr_chk #(
  parameter int PROG_CYCLES = 2000,
  parameter int CSL_MIN     = 8,
  parameter bit TRIG_ON_CS  = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic cs,
  input logic do_o,
  input logic do_oe,
  input logic wr_go
);
  localparam int SW = $clog2(PROG_CYCLES + 8);
  localparam int LW = $clog2(CSL_MIN + 2);
  localparam logic [SW-1:0] SINCE_MAX = SW'(PROG_CYCLES + 4);
  localparam logic [LW-1:0] LOW_MAX   = LW'(CSL_MIN + 1);

  logic [SW-1:0] since;
  logic [LW-1:0] lowc;
  logic          cs_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= SINCE_MAX;
      lowc  <= '0;
      cs_p  <= 1'b0;
    end else begin
      cs_p <= cs;
      if (wr_go)
        since <= '0;
      else if (since != SINCE_MAX)
        since <= since + 1'b1;
      if (!cs) begin
        if (cs_p)
          lowc <= LW'(1);
        else if (lowc != LOW_MAX)
          lowc <= lowc + 1'b1;
      end
    end
  end

  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    do_oe |-> $past(cs)); // R6

  AST_BUSY_READS_LOW: assert property (@(posedge clk) disable iff (rst)
    (do_oe && since < SW'(PROG_CYCLES - 2)) |-> !do_o); // R4

  AST_READY_READS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (do_oe && since > SW'(PROG_CYCLES + 1)) |-> do_o); // R4

  AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    wr_go |-> since >= SW'(PROG_CYCLES)); // R8

  AST_WINDOW_MIN_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(do_oe) |-> lowc >= LW'(CSL_MIN)); // R5

  AST_TRIGGER_EDGE: assert property (@(posedge clk) disable iff (rst)
    wr_go |-> (TRIG_ON_CS ? !cs : cs)); // R3
endmodule

bind mw_eeprom_wr mw_eeprom_wr_chk #(
  .PROG_CYCLES(PROG_CYCLES), .CSL_MIN(CSL_MIN), .TRIG_ON_CS(TRIG_ON_CS)
) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .do_o(do_o), .do_oe(do_oe), .wr_go(wr_go)
);

// File: tb/mw_eeprom_wr_tb.sv
module mw_eeprom_wr_tb;
  localparam int PROG = 300;
  localparam int CSLM = 4;
  localparam int NVEC = 10;

  // fields: [27] org, [26:25] opcode, [24:16] address, [15:0] data
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b1, 2'b01, 9'h012, 16'hA5C3},
    {1'b0, 2'b01, 9'h024, 16'h007E},
    {1'b0, 2'b01, 9'h025, 16'h0019},
    {1'b1, 2'b01, 9'h0FF, 16'h0001},
    {1'b1, 2'b01, 9'h000, 16'h3C3C},
    {1'b0, 2'b01, 9'h001, 16'h00FF},
    {1'b1, 2'b11, 9'h012, 16'hDEAD},
    {1'b1, 2'b10, 9'h0FF, 16'h1234},
    {1'b0, 2'b01, 9'h1FF, 16'h0080},
    {1'b0, 2'b00, 9'h025, 16'h0055}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sck = 1'b0, di = 1'b0, org = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic        do_a, oe_a, do_b, oe_b;
  logic [15:0] rd_a, rd_b;
  logic [15:0] model [256];
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mw_eeprom_wr #(.WORD_ADDR_W(8), .PROG_CYCLES(PROG), .CSL_MIN(CSLM), .TRIG_ON_CS(1'b1)) u_dut (
    .clk(clk), .rst(rst), .cs(cs), .sck(sck), .di(di), .org(org),
    .do_o(do_a), .do_oe(oe_a), .rd_addr(rd_addr), .rd_data(rd_a));

  mw_eeprom_wr #(.WORD_ADDR_W(8), .PROG_CYCLES(PROG), .CSL_MIN(CSLM), .TRIG_ON_CS(1'b0)) u_lc (
    .clk(clk), .rst(rst), .cs(cs), .sck(sck), .di(di), .org(org),
    .do_o(do_b), .do_oe(oe_b), .rd_addr(rd_addr), .rd_data(rd_b));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    di  = b;
    sck = 1'b0;
    repeat (2) @(negedge clk);
    sck = 1'b1;
    repeat (2) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic send_frame(input logic o, input logic [1:0] op, input logic [8:0] a,
                            input logic [15:0] d, input int nlead, input int keep);
    int alen = o ? 8 : 9;
    int dlen = o ? 16 : 8;
    int sent = 0;
    @(negedge clk);
    cs = 1'b1; org = o; sck = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nlead; i++) send_bit(1'b0);
    send_bit(1'b1);
    send_bit(op[1]);
    send_bit(op[0]);
    for (int i = alen - 1; i >= 0; i--)
      if (sent < keep) begin send_bit(a[i]); sent++; end
    for (int i = dlen - 1; i >= 0; i--)
      if (sent < keep) begin send_bit(d[i]); sent++; end
  endtask

  task automatic cs_low(input int n);
    @(negedge clk);
    cs = 1'b0; sck = 1'b0; di = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_high(input int n);
    @(negedge clk);
    cs = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic read_word(input logic [7:0] a);
    @(negedge clk);
    rd_addr = a;
    repeat (2) @(negedge clk);
  endtask

  task automatic full_write(input logic [7:0] a, input logic [15:0] d);
    send_frame(1'b1, 2'b01, {1'b0, a}, d, 1, 99);
    cs_low(6);
    repeat (PROG + 20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 reset oe", {15'd0, oe_a}, 16'd0);
    check("R6 reset oe lc", {15'd0, oe_b}, 16'd0);

    // R1 R2 R10: table walk with varying leading zeros
    for (int v = 0; v < NVEC; v++) begin
      logic       o  = VEC[v][27];
      logic [1:0] op = VEC[v][26:25];
      logic [8:0] a  = VEC[v][24:16];
      logic [15:0] d = VEC[v][15:0];
      logic [7:0] w  = o ? a[7:0] : a[8:1];
      send_frame(o, op, a, d, v % 4, 99);
      cs_low(6);
      repeat (PROG + 20) @(negedge clk);
      if (op == 2'b01) begin
        if (o) model[w] = d;
        else if (a[0]) model[w][15:8] = d[7:0];
        else model[w][7:0] = d[7:0];
      end
      read_word(w);
      check(op == 2'b01 ? "R1/R2/R11 write" : "R10 foreign opcode", rd_a, model[w]);
      check(op == 2'b01 ? "R1/R2 write lc" : "R10 foreign opcode lc", rd_b, model[w]);
    end

    // R4: busy then ready on the status pin
    send_frame(1'b1, 2'b01, 9'h030, 16'h1357, 0, 99);
    cs_low(6);
    cs_high(3);
    check("R4 oe during programming", {15'd0, oe_a}, 16'd1);
    check("R4 busy reads 0", {15'd0, do_a}, 16'd0);
    check("R4 busy reads 0 lc", {15'd0, do_b}, 16'd0);
    repeat (PROG + 10) @(negedge clk);
    check("R4 ready reads 1", {15'd0, do_a}, 16'd1);
    check("R4 ready reads 1 lc", {15'd0, do_b}, 16'd1);

    // R5: too short a low time opens no window
    cs_low(2);
    cs_high(3);
    check("R5 short low oe", {15'd0, oe_a}, 16'd0);
    check("R5 short low oe lc", {15'd0, oe_b}, 16'd0);
    cs_low(6);
    cs_high(3);
    check("R4 status persists", {15'd0, oe_a}, 16'd1);
    check("R6 oe low with cs low", {15'd0, oe_a & ~cs}, 16'd0);

    // R7: start bit then cs low removes status
    @(negedge clk);
    send_bit(1'b1);
    cs_low(6);
    cs_high(3);
    check("R7 cleared oe", {15'd0, oe_a}, 16'd0);
    check("R7 cleared oe lc", {15'd0, oe_b}, 16'd0);
    cs_low(6);

    // R9: partial frame discarded
    full_write(8'h40, 16'h1111);
    send_frame(1'b1, 2'b01, 9'h040, 16'h2222, 0, 18);
    cs_low(6);
    repeat (PROG + 20) @(negedge clk);
    read_word(8'h40);
    check("R9 partial frame", rd_a, 16'h1111);
    check("R9 partial frame lc", rd_b, 16'h1111);

    // R8: frame during programming ignored
    send_frame(1'b1, 2'b01, 9'h050, 16'hAAAA, 0, 99);
    cs_low(6);
    send_frame(1'b1, 2'b01, 9'h050, 16'h5555, 0, 99);
    cs_low(6);
    repeat (PROG + 20) @(negedge clk);
    read_word(8'h50);
    check("R8 busy frame ignored", rd_a, 16'hAAAA);
    check("R8 busy frame ignored lc", rd_b, 16'hAAAA);

    // R3: commit point of each variant
    full_write(8'h60, 16'h0000);
    send_frame(1'b1, 2'b01, 9'h060, 16'hCAFE, 0, 99);
    repeat (4) @(negedge clk);
    read_word(8'h60);
    check("R3 cs-fall variant waits", rd_a, 16'h0000);
    check("R3 last-clock variant commits", rd_b, 16'hCAFE);
    cs_low(6);
    repeat (PROG + 20) @(negedge clk);
    read_word(8'h60);
    check("R3 cs-fall variant commits", rd_a, 16'hCAFE);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule